// File: doc/BRIEF.md
# Addressable Debug Scan Chain Controller

The block holds a group of functional state registers organised as several independent serial scan chains. Each chain has its own length and its own shadow shift register. A host addresses one chain at a time through a small command port. It can copy that chain's live register values into the shadow bits, move the shadow bits out one bit per scan tick while new bits come in, and then have the shadow contents written back into the functional registers.

Scan work happens only while the functional logic is quiescent. The host must wait for `cmd_ready`, which stays low while the functional enable is high. While a command runs, the functional outputs hold their values whatever the functional enable and data do. An UPDATE command does not write the functional registers at once. It arms a transfer, and that transfer happens on the first cycle that normal clocking resumes.

Commands take a two-bit opcode. Code 0 is SELECT, with the chain index in `cmd_arg`. Code 1 is CAPTURE. Code 2 is SHIFT, with the bit count in `cmd_arg`. Code 3 is UPDATE. The sequencer has four states:
- IDLE accepts commands.
- CAPT lasts one cycle and loads the shadow bits.
- SHIFT runs until the requested number of ticks has been seen.
- UPD lasts one cycle and arms the deferred transfer.

The transitions are:
- IDLE→CAPT on an accepted CAPTURE.
- IDLE→SHIFT on an accepted SHIFT with a nonzero count.
- IDLE→UPD on an accepted UPDATE.
- CAPT→IDLE after one cycle.
- UPD→IDLE after one cycle.
- SHIFT→IDLE on the tick that moves the last requested bit.

SELECT, and SHIFT with a count of zero, finish without leaving IDLE.

Top module: `dbg_scan_hub`

## Requirements
- R1: After reset, all `func_q` bits are 0, `busy` is 0, `sel_err` is 0, chain 0 is selected, and `cmd_ready` is 1 while `func_en` is low.
- R2: When `func_en` is high, no command is running and no transfer is armed, each chain's functional register takes `func_d` one cycle later. Bits at or above a chain's length always read 0.
- R3: `cmd_ready` is low whenever `func_en` is high or a command is running. A command held on `cmd_valid` stalls until `cmd_ready` rises.
- R4: A SELECT (op 0) whose index is below the chain count selects that chain and clears `sel_err`. A larger index sets `sel_err` and leaves the selection unchanged.
- R5: CAPTURE (op 1) copies the selected chain's functional values into its shadow bits. `busy` is high for exactly one cycle after acceptance.
- R6: SHIFT (op 2) with count n>0 moves the selected shadow register one position on each cycle with `scan_tick` high. `scan_si` enters bit 0. Cycles without a tick do not shift. `busy` falls after the n-th tick.
- R7: `scan_so` always shows the top bit (length−1) of the selected chain's shadow. A full-length shift after CAPTURE therefore emits the captured bits from the top bit down to bit 0.
- R8: Chains that are not selected neither capture nor shift, and their shadow contents are preserved.
- R9: While `busy` is high, `func_q` does not change, even if `func_en` and `func_d` do.
- R10: UPDATE (op 3) is busy for one cycle and arms a transfer for the chain selected at that time. On the next cycle with `func_en` high and no command running, that chain loads its shadow bits instead of `func_d`, while the other chains load `func_d`.
- R11: UPDATE is legal without a preceding shift and transfers whatever the shadow holds at that point.
- R12: SHIFT with a count of 0 completes with `busy` staying low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| func_en | input | 1 | Functional load enable (normal clocking) |
| func_d | input | NUM_CHAINS*MAX_LEN | Functional next-state data, MAX_LEN bits per chain |
| func_q | output | NUM_CHAINS*MAX_LEN | Functional register outputs, MAX_LEN bits per chain |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Opcode: 0 SELECT, 1 CAPTURE, 2 SHIFT, 3 UPDATE |
| cmd_arg | input | ARG_W | Chain index (SELECT) or bit count (SHIFT) |
| cmd_ready | output | 1 | Command accepted on this edge when high with cmd_valid |
| busy | output | 1 | A capture, shift or update is running |
| sel_err | output | 1 | Last SELECT carried an index beyond the chain count |
| scan_tick | input | 1 | Scan clock strobe, one bit per high cycle |
| scan_si | input | 1 | Serial scan input |
| scan_so | output | 1 | Serial scan output from the selected chain |

## Verification
The bench builds the block with four chains of lengths 5, 16, 12 and 8, a 16-bit maximum length and a 3-bit index field. This mix covers:
- a chain that fills the whole width, which checks that no bit is masked off;
- short chains, which check the masking of unused bits;
- SELECT indices 4 to 7, which exercise the error path.

Random tick gaps, with the functional enable toggled inside those gaps, probe the freeze while busy. Full-length and partial shifts followed by UPDATE are checked on every chain, and the deferred transfer is checked against chains that load plain data in the same cycle.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;

    typedef enum logic [1:0] {
        OP_SELECT  = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2,
        OP_UPDATE  = 2'd3
    } scan_op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CAPT  = 2'd1,
        S_SHIFT = 2'd2,
        S_UPD   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/dbg_scan_seq.sv
module dbg_scan_seq
    import dbg_scan_pkg::*;
#(
    parameter int NUM_CHAINS = 4,
    parameter int SEL_W      = 3,
    parameter int ARG_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             func_en,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [ARG_W-1:0] cmd_arg,
    input  logic             scan_tick,
    output logic             cmd_ready,
    output logic             busy,
    output logic             sel_err,
    output logic [SEL_W-1:0] sel_idx,
    output logic             capture_en,
    output logic             shift_en,
    output logic             apply_en,
    output logic [SEL_W-1:0] apply_idx
);

    localparam logic [ARG_W-1:0] CHAIN_LIMIT = ARG_W'(NUM_CHAINS);

    seq_state_e       state_q, state_d;
    logic [ARG_W-1:0] bits_left_q;
    logic             armed_q;
    logic             accept;
    scan_op_e         op;

    assign op     = scan_op_e'(cmd_op);
    assign accept = cmd_valid && cmd_ready;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_CAPTURE: state_d = S_CAPT;
                        OP_SHIFT:   state_d = (cmd_arg != '0) ? S_SHIFT : S_IDLE;
                        OP_UPDATE:  state_d = S_UPD;
                        OP_SELECT:  state_d = S_IDLE;
                    endcase
                end
            end
            S_CAPT:  state_d = S_IDLE;
            S_SHIFT: if (scan_tick && bits_left_q == ARG_W'(1)) state_d = S_IDLE;
            S_UPD:   state_d = S_IDLE;
        endcase
    end

    // state register with its bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            bits_left_q <= '0;
            sel_idx     <= '0;
            sel_err     <= 1'b0;
            armed_q     <= 1'b0;
            apply_idx   <= '0;
        end else begin
            state_q <= state_d;
            if (accept && op == OP_SELECT) begin
                if (cmd_arg < CHAIN_LIMIT) begin
                    sel_idx <= cmd_arg[SEL_W-1:0];
                    sel_err <= 1'b0;
                end else begin
                    sel_err <= 1'b1;
                end
            end
            if (accept && op == OP_SHIFT)
                bits_left_q <= cmd_arg;
            else if (state_q == S_SHIFT && scan_tick)
                bits_left_q <= bits_left_q - ARG_W'(1);
            if (state_q == S_UPD) begin
                armed_q   <= 1'b1;
                apply_idx <= sel_idx;
            end else if (apply_en) begin
                armed_q <= 1'b0;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        cmd_ready  = 1'b0;
        busy       = 1'b1;
        capture_en = 1'b0;
        shift_en   = 1'b0;
        apply_en   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy      = 1'b0;
                cmd_ready = !func_en;
                apply_en  = armed_q && func_en;
            end
            S_CAPT:  capture_en = 1'b1;
            S_SHIFT: shift_en   = scan_tick;
            S_UPD:   ;
        endcase
    end

endmodule

// File: rtl/dbg_scan_slice.sv
module dbg_scan_slice #(
    parameter int MAX_LEN = 16,
    parameter int LEN     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_func,
    input  logic [MAX_LEN-1:0] func_d,
    input  logic               apply,
    input  logic               capture,
    input  logic               shift,
    input  logic               si,
    output logic [MAX_LEN-1:0] func_q,
    output logic               so
);

    localparam logic [MAX_LEN:0]   ONE_UP = (MAX_LEN+1)'(1) << LEN;
    localparam logic [MAX_LEN-1:0] MASK   = MAX_LEN'(ONE_UP - (MAX_LEN+1)'(1));
    localparam logic [MAX_LEN-1:0] TOPBIT = MAX_LEN'(1) << (LEN - 1);

    logic [MAX_LEN-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            func_q <= '0;
        else if (apply)
            func_q <= shadow_q;
        else if (load_func)
            func_q <= func_d & MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_q <= '0;
        else if (capture)
            shadow_q <= func_q;
        else if (shift)
            shadow_q <= {shadow_q[MAX_LEN-2:0], si} & MASK;
    end

    assign so = |(shadow_q & TOPBIT);

endmodule

// File: rtl/dbg_scan_hub.sv
module dbg_scan_hub
    import dbg_scan_pkg::*;
#(
    parameter int NUM_CHAINS          = 4,
    parameter int MAX_LEN             = 16,
    parameter int SEL_W               = 3,
    parameter int ARG_W               = 8,
    parameter int LEN_OF [NUM_CHAINS] = '{5, 16, 12, 8}
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          func_en,
    input  logic [NUM_CHAINS*MAX_LEN-1:0] func_d,
    output logic [NUM_CHAINS*MAX_LEN-1:0] func_q,
    input  logic                          cmd_valid,
    input  logic [1:0]                    cmd_op,
    input  logic [ARG_W-1:0]              cmd_arg,
    output logic                          cmd_ready,
    output logic                          busy,
    output logic                          sel_err,
    input  logic                          scan_tick,
    input  logic                          scan_si,
    output logic                          scan_so
);

    logic [SEL_W-1:0]      sel_idx;
    logic [SEL_W-1:0]      apply_idx;
    logic                  capture_en;
    logic                  shift_en;
    logic                  apply_en;
    logic [NUM_CHAINS-1:0] chain_so;
    logic                  load_func;

    dbg_scan_seq #(
        .NUM_CHAINS (NUM_CHAINS),
        .SEL_W      (SEL_W),
        .ARG_W      (ARG_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .func_en    (func_en),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_arg    (cmd_arg),
        .scan_tick  (scan_tick),
        .cmd_ready  (cmd_ready),
        .busy       (busy),
        .sel_err    (sel_err),
        .sel_idx    (sel_idx),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .apply_en   (apply_en),
        .apply_idx  (apply_idx)
    );

    assign load_func = func_en && !busy;

    for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_chain
        logic hit_sel;
        logic hit_apply;
        assign hit_sel   = (sel_idx == SEL_W'(g));
        assign hit_apply = apply_en && (apply_idx == SEL_W'(g));

        dbg_scan_slice #(
            .MAX_LEN (MAX_LEN),
            .LEN     (LEN_OF[g])
        ) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_func (load_func),
            .func_d    (func_d[g*MAX_LEN +: MAX_LEN]),
            .apply     (hit_apply),
            .capture   (capture_en && hit_sel),
            .shift     (shift_en && hit_sel),
            .si        (scan_si),
            .func_q    (func_q[g*MAX_LEN +: MAX_LEN]),
            .so        (chain_so[g])
        );
    end

    always_comb begin
        scan_so = 1'b0;
        for (int c = 0; c < NUM_CHAINS; c++)
            if (sel_idx == SEL_W'(c)) scan_so = chain_so[c];
    end

endmodule

// File: rtl/dbg_scan_hub_chk.sv
module dbg_scan_hub_chk #(
    parameter int NUM_CHAINS = 4,
    parameter int MAX_LEN    = 16,
    parameter int ARG_W      = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          func_en,
    input logic [NUM_CHAINS*MAX_LEN-1:0] func_q,
    input logic                          cmd_valid,
    input logic [1:0]                    cmd_op,
    input logic [ARG_W-1:0]              cmd_arg,
    input logic                          cmd_ready,
    input logic                          busy,
    input logic                          sel_err
);

    logic acc;
    assign acc = cmd_valid && cmd_ready;

    assert_frozen_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(func_q));

    assert_ready_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!busy && !func_en));

    assert_capture_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 2'd1) |=> busy ##1 !busy);

    assert_zero_shift_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 2'd2 && cmd_arg == '0) |=> !busy);

    assert_shift_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 2'd2 && cmd_arg != '0) |=> busy);

    assert_bad_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 2'd0 && cmd_arg >= ARG_W'(NUM_CHAINS)) |=> sel_err);

    assert_good_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 2'd0 && cmd_arg < ARG_W'(NUM_CHAINS)) |=> !sel_err);

    assert_update_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 2'd3) |=> busy ##1 !busy);

endmodule

bind dbg_scan_hub dbg_scan_hub_chk #(
    .NUM_CHAINS (NUM_CHAINS),
    .MAX_LEN    (MAX_LEN),
    .ARG_W      (ARG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .func_en   (func_en),
    .func_q    (func_q),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_arg   (cmd_arg),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .sel_err   (sel_err)
);

// File: tb/dbg_scan_hub_test.sv
module dbg_scan_hub_test;

    localparam int NC   = 4;
    localparam int ML   = 16;
    localparam int SW   = 3;
    localparam int AW   = 8;
    localparam int LENS [NC] = '{5, 16, 12, 8};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              func_en = 1'b0;
    logic [NC*ML-1:0]  func_d = '0;
    logic [NC*ML-1:0]  func_q;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = '0;
    logic [AW-1:0]     cmd_arg = '0;
    logic              cmd_ready, busy, sel_err;
    logic              scan_tick = 1'b0;
    logic              scan_si = 1'b0;
    logic              scan_so;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [ML-1:0] ref_func   [NC];
    logic [ML-1:0] ref_shadow [NC];
    int            ref_sel = 0;
    bit            ref_pend = 0;
    int            ref_pchain = 0;

    always #10 clk = ~clk;

    dbg_scan_hub #(
        .NUM_CHAINS (NC), .MAX_LEN (ML), .SEL_W (SW), .ARG_W (AW), .LEN_OF (LENS)
    ) uut (
        .clk (clk), .rst_n (rst_n), .func_en (func_en), .func_d (func_d),
        .func_q (func_q), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_arg (cmd_arg), .cmd_ready (cmd_ready), .busy (busy),
        .sel_err (sel_err), .scan_tick (scan_tick), .scan_si (scan_si),
        .scan_so (scan_so)
    );

    function automatic logic [ML-1:0] mask_of(int c);
        return ML'(({(ML+1){1'b0}} | ((ML+1)'(1) << LENS[c])) - (ML+1)'(1));
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_func(string req);
        for (int c = 0; c < NC; c++)
            chk(req, 64'(func_q[c*ML +: ML]), 64'(ref_func[c]));
    endtask

    // one cycle of normal clocking with random data; models deferred transfer
    task automatic func_cycle(string req);
        logic [NC*ML-1:0] d;
        for (int c = 0; c < NC; c++) d[c*ML +: ML] = ML'($urandom);
        @(negedge clk);
        func_en = 1'b1;
        func_d  = d;
        @(negedge clk);
        func_en = 1'b0;
        for (int c = 0; c < NC; c++)
            ref_func[c] = (ref_pend && c == ref_pchain) ? ref_shadow[c]
                                                        : (d[c*ML +: ML] & mask_of(c));
        ref_pend = 0;
        chk_func(req);
    endtask

    task automatic do_cmd(logic [1:0] op, logic [AW-1:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = arg;
        #1;
        while (!cmd_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_select(int idx);
        do_cmd(2'd0, AW'(idx));
        if (idx < NC) begin
            ref_sel = idx;
            chk("R4 sel_err clear", 64'(sel_err), 64'd0);
        end else begin
            chk("R4 sel_err set", 64'(sel_err), 64'd1);
        end
    endtask

    task automatic do_capture();
        do_cmd(2'd1, '0);
        chk("R5 busy during capture", 64'(busy), 64'd1);
        @(negedge clk);
        chk("R5 busy after capture", 64'(busy), 64'd0);
        ref_shadow[ref_sel] = ref_func[ref_sel];
        chk("R5 R7 top bit after capture", 64'(scan_so),
            64'(ref_shadow[ref_sel][LENS[ref_sel]-1]));
    endtask

    task automatic do_shift(int n);
        int L;
        logic b;
        L = LENS[ref_sel];
        do_cmd(2'd2, AW'(n));
        chk("R12 R6 busy after shift accept", 64'(busy), 64'(n != 0));
        for (int i = 0; i < n; i++) begin
            repeat ($urandom % 3) begin
                func_en = 1'b1;
                func_d  = {NC{16'hFFFF}} ^ {NC*ML{1'($urandom)}};
                scan_tick = 1'b0;
                @(negedge clk);
                func_en = 1'b0;
                chk_func("R9 frozen while shifting");
                chk("R3 ready low while busy", 64'(cmd_ready), 64'd0);
            end
            b = 1'($urandom);
            scan_si   = b;
            scan_tick = 1'b1;
            chk("R7 serial out order", 64'(scan_so), 64'(ref_shadow[ref_sel][L-1]));
            @(negedge clk);
            scan_tick = 1'b0;
            ref_shadow[ref_sel] = ((ref_shadow[ref_sel] << 1) | ML'(b)) & mask_of(ref_sel);
        end
        chk("R6 busy low after last tick", 64'(busy), 64'd0);
        chk("R6 R7 top bit after shift", 64'(scan_so), 64'(ref_shadow[ref_sel][L-1]));
    endtask

    task automatic do_update();
        do_cmd(2'd3, '0);
        chk("R10 busy during update", 64'(busy), 64'd1);
        @(negedge clk);
        chk("R10 busy after update", 64'(busy), 64'd0);
        chk_func("R10 transfer deferred");
        ref_pend   = 1;
        ref_pchain = ref_sel;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int c = 0; c < NC; c++) begin
            ref_func[c]   = '0;
            ref_shadow[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_func("R1 reset func_q");
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 sel_err", 64'(sel_err), 64'd0);
        chk("R1 cmd_ready", 64'(cmd_ready), 64'd1);
        chk("R1 so chain0", 64'(scan_so), 64'd0);

        // R2 normal loading with masking
        repeat (3) func_cycle("R2 functional load");

        // R3 stall while func_en high
        cmd_valid = 1'b1;
        cmd_op    = 2'd1;
        cmd_arg   = '0;
        for (int k = 0; k < 3; k++) begin
            logic [NC*ML-1:0] d;
            for (int c = 0; c < NC; c++) d[c*ML +: ML] = ML'($urandom);
            func_en = 1'b1;
            func_d  = d;
            #1;
            chk("R3 ready low with func_en", 64'(cmd_ready), 64'd0);
            @(negedge clk);
            for (int c = 0; c < NC; c++) ref_func[c] = d[c*ML +: ML] & mask_of(c);
            chk("R3 stalled not busy", 64'(busy), 64'd0);
            chk_func("R2 load during stall");
        end
        func_en = 1'b0;
        #1;
        chk("R3 ready after func_en drop", 64'(cmd_ready), 64'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R3 R5 stalled capture runs", 64'(busy), 64'd1);
        @(negedge clk);
        ref_shadow[0] = ref_func[0];

        // R4 bad selects keep the selection
        do_select(2);
        do_select(5);
        do_select(7);
        do_capture();          // must hit chain 2
        do_shift(LENS[2]);
        do_select(2);

        // R8 preserved shadows across chains
        do_select(1);
        do_capture();
        do_select(3);
        do_capture();
        func_cycle("R2 load between captures");
        do_select(1);
        do_shift(LENS[1]);     // chain 1 unaffected by chain 3 capture and new func
        do_select(3);
        do_shift(3);           // partial
        do_shift(LENS[3] - 3);

        // R12 zero-length shift
        do_select(0);
        do_shift(0);

        // R11 update straight after capture
        do_select(2);
        func_cycle("R2 load before capture");
        do_capture();
        do_update();
        func_cycle("R11 update without shift");

        // per-chain capture / shift / update rounds
        for (int round = 0; round < 3; round++) begin
            for (int c = 0; c < NC; c++) begin
                func_cycle("R2 load before round");
                do_select(c);
                do_capture();
                do_shift(LENS[c]);
                do_update();
                func_cycle("R10 deferred transfer applied");
                func_cycle("R2 load after transfer");
                if (round == 2) begin
                    do_select(c);
                    do_shift(1 + ($urandom % LENS[c]));
                    do_update();
                    func_cycle("R10 transfer after partial shift");
                end
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule